// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog for a small processor subsystem. A free-running counter on the system clock is restarted by a software strobe. If software fails to restart it before the selected timeout, the block first sets an interrupt flag. It also raises an interrupt request when interrupts are enabled. This gives firmware one last chance to recover.

The expiry opens a reset window of fixed length. If no restart arrives before the window ends, the block emits a one-cycle system reset request, provided reset generation is enabled. A restart at any point clears the counter and cancels a pending window. The interrupt flag stays set until software clears it explicitly.

The timeout lengths and the window length are parameters. By default they give 2^15, 2^18, 2^21 or 2^24 cycles for the timeout and 512 cycles for the window. At a 12 MHz clock these are about 2.7 ms, 21.9 ms, 174.7 ms and 1.4 s, and the window is about 42.7 µs. Each timeout must be longer than the window.

Top module: `wdt_twostage`

## Requirements
- R1: With L = 2^(BASE_LOG + STEP_LOG*sel), where the 2-bit select gives sel 0..3 (00, 01, 10, 11), the flag sets on the L-th rising edge at which the block is enabled and not restarted. The count runs since the last restart, the last disabled cycle or the last expiry.
- R2: The flag sets on expiry and holds until a clear strobe. A clear strobe sampled on the same edge as an expiry leaves the flag set.
- R3: The interrupt output equals the flag ANDed with the interrupt enable.
- R4: The reset request is a one-cycle pulse on the WIN_CYC-th edge after the edge that set the flag from an expiry, and only if the reset enable is 1 on that edge.
- R5: A restart clears the counter, so restarts spaced closer than L edges never set the flag.
- R6: A restart during the reset window cancels it. This includes a restart sampled on the window's final edge, which suppresses the reset request.
- R7: A restart does not clear the flag.
- R8: While the enable is 0, the counter and the window are held cleared, no expiry and no reset request occur, and restart strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wd_en_i | input | 1 | Watchdog enable |
| tsel_i | input | 2 | Timeout select: 00 shortest to 11 longest |
| irq_en_i | input | 1 | Interrupt request enable |
| kick_i | input | 1 | Restart strobe |
| rst_en_i | input | 1 | Reset request enable |
| flag_clr_i | input | 1 | Interrupt flag clear strobe |
| irq_o | output | 1 | Interrupt request |
| flag_o | output | 1 | Interrupt flag |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Two pairs of functions can meet on one edge. One pair is a flag-clear strobe and the expiry that sets the flag; the other is a restart and the last edge of the reset window. The bench places each strobe on exactly that edge by counting edges from a preceding restart. A behavioural model, compared on every clock, then judges the result: set must win over clear, and a restart must win over the reset pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        TSEL_SHORT  = 2'b00,
        TSEL_MID    = 2'b01,
        TSEL_LONG   = 2'b10,
        TSEL_LONGEST = 2'b11
    } tsel_e;

    localparam int NUM_TSEL = 4;

endpackage

// File: rtl/wdt_term_dec.sv
module wdt_term_dec #(
    parameter int CW       = 24,
    parameter int BASE_LOG = 15,
    parameter int STEP_LOG = 3
) (
    input  logic [CW-1:0]      cnt_i,
    input  wdt_pkg::tsel_e     sel_i,
    output logic               hit_o
);
    logic [wdt_pkg::NUM_TSEL-1:0] hits;

    // each select ends the interval when the low LG bits are all ones
    for (genvar g = 0; g < wdt_pkg::NUM_TSEL; g++) begin : g_tc
        localparam int LG = BASE_LOG + STEP_LOG * g;
        assign hits[g] = &cnt_i[LG-1:0];
    end

    assign hit_o = hits[sel_i];
endmodule

// File: rtl/wdt_rst_window.sv
module wdt_rst_window #(
    parameter int WIN_CYC = 512
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic arm_i,
    input  logic rst_en_i,
    output logic rst_req_o
);
    localparam int WW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
    localparam logic [WW-1:0] LAST = WW'(WIN_CYC - 1);

    typedef struct packed {
        logic          act;
        logic [WW-1:0] cnt;
        logic          pulse;
    } win_t;

    win_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (clear_i) begin
            s_d.act = 1'b0;
            s_d.cnt = '0;
        end else if (arm_i) begin
            s_d.act = 1'b1;
            s_d.cnt = '0;
        end else if (s_q.act) begin
            if (s_q.cnt == LAST) begin
                s_d.act   = 1'b0;
                s_d.cnt   = '0;
                s_d.pulse = rst_en_i;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rst_req_o = s_q.pulse;
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage #(
    parameter int BASE_LOG = 15,
    parameter int STEP_LOG = 3,
    parameter int WIN_CYC  = 512
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wd_en_i,
    input  logic [1:0] tsel_i,
    input  logic       irq_en_i,
    input  logic       kick_i,
    input  logic       rst_en_i,
    input  logic       flag_clr_i,
    output logic       irq_o,
    output logic       flag_o,
    output logic       rst_req_o
);
    localparam int CW = BASE_LOG + 3 * STEP_LOG;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } core_t;

    core_t s_d, s_q;
    logic  hit;
    logic  expire;
    logic  hold;

    wdt_term_dec #(
        .CW       (CW),
        .BASE_LOG (BASE_LOG),
        .STEP_LOG (STEP_LOG)
    ) u_dec (
        .cnt_i (s_q.cnt),
        .sel_i (wdt_pkg::tsel_e'(tsel_i)),
        .hit_o (hit)
    );

    assign hold   = !wd_en_i || kick_i;
    assign expire = !hold && hit;

    wdt_rst_window #(
        .WIN_CYC (WIN_CYC)
    ) u_win (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (hold),
        .arm_i     (expire),
        .rst_en_i  (rst_en_i),
        .rst_req_o (rst_req_o)
    );

    always_comb begin
        s_d = s_q;
        if (hold || hit) s_d.cnt = '0;
        else             s_d.cnt = s_q.cnt + 1'b1;
        if (flag_clr_i) s_d.flag = 1'b0;
        if (expire)     s_d.flag = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign flag_o = s_q.flag;
    assign irq_o  = s_q.flag & irq_en_i;
endmodule

// File: rtl/wdt_twostage_chk.sv
module wdt_twostage_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic wd_en_i,
    input logic irq_en_i,
    input logic kick_i,
    input logic rst_en_i,
    input logic flag_clr_i,
    input logic irq_o,
    input logic flag_o,
    input logic rst_req_o
);
    // R4
    rst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |=> !rst_req_o);

    // R4
    rst_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> $past(rst_en_i));

    // R3
    irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> flag_o);

    // R6
    kick_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kick_i && wd_en_i) |=> !rst_req_o);

    // R7
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !flag_clr_i) |=> flag_o);

    // R8
    off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wd_en_i |=> !rst_req_o);

    // R8
    off_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wd_en_i && !flag_o) |=> !flag_o);
endmodule

bind wdt_twostage wdt_twostage_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wd_en_i    (wd_en_i),
    .irq_en_i   (irq_en_i),
    .kick_i     (kick_i),
    .rst_en_i   (rst_en_i),
    .flag_clr_i (flag_clr_i),
    .irq_o      (irq_o),
    .flag_o     (flag_o),
    .rst_req_o  (rst_req_o)
);

// File: tb/wdt_twostage_tb_top.sv
`timescale 1ns/1ps
module wdt_twostage_tb_top;
    localparam int BASE = 6;
    localparam int STEP = 2;
    localparam int WIN  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 0, irq_en = 0, kick = 0, rst_en = 0, fclr = 0;
    logic [1:0] tsel = 2'b00;
    logic irq, flag, rreq;

    always #2.5 clk = ~clk;

    wdt_twostage #(.BASE_LOG(BASE), .STEP_LOG(STEP), .WIN_CYC(WIN)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wd_en_i(en), .tsel_i(tsel),
        .irq_en_i(irq_en), .kick_i(kick), .rst_en_i(rst_en),
        .flag_clr_i(fclr), .irq_o(irq), .flag_o(flag), .rst_req_o(rreq));

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int pulses = 0;
    bit done = 0;

    // behavioural reference
    int  elapsed;
    bit  win_on;
    int  win_cnt;
    bit  m_flag;
    bit  m_rst;

    always @(posedge clk) begin
        if (!rst_n) begin
            elapsed = 0; win_on = 0; win_cnt = 0; m_flag = 0; m_rst = 0;
        end else begin
            int lim;
            bit exp_now;
            lim = 1 << (BASE + STEP * tsel);
            m_rst = 0;
            if (!en || kick) begin
                elapsed = 0; win_on = 0; win_cnt = 0;
                if (fclr) m_flag = 0;
            end else begin
                exp_now = ((elapsed + 1) % lim) == 0;
                if (fclr) m_flag = 0;
                if (exp_now) m_flag = 1;
                if (win_on) begin
                    win_cnt++;
                    if (win_cnt == WIN) begin
                        m_rst = rst_en; win_on = 0; win_cnt = 0;
                    end
                end
                if (exp_now) begin
                    elapsed = 0; win_on = 1; win_cnt = 0;
                end else elapsed++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        cyc++;
        if (rst_n && !done) begin
            chk("R1 R2 R5 R7 R8 flag", flag, m_flag);
            chk("R3 irq", irq, m_flag && irq_en);
            chk("R4 R6 rst_req", rreq, m_rst);
            if (rreq) pulses++;
        end
        if (cyc > 60000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog R1 actual=%0d expected=<60000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_kick();
        kick = 1; @(negedge clk); kick = 0;
    endtask

    task automatic pulse_clr();
        fclr = 1; @(negedge clk); fclr = 0;
    endtask

    initial begin
        int p0;
        step(3);
        chk("R2 reset flag", flag, 0);
        chk("R4 reset rst_req", rreq, 0);
        rst_n = 1;
        step(2);

        // R1: shortest select counted from enable
        irq_en = 1; rst_en = 1; tsel = 2'b00; en = 1;
        step(63);
        chk("R1 no flag before 64", flag, 0);
        step(1);
        chk("R1 flag at 64", flag, 1);
        chk("R3 irq with enable", irq, 1);
        // R4: reset after window
        p0 = pulses;
        step(WIN + 4);
        chk("R4 one reset pulse", pulses - p0, 1);

        // R5: periodic restarts keep flag low
        pulse_kick(); pulse_clr();
        p0 = pulses;
        for (int i = 0; i < 8; i++) begin
            step(50);
            pulse_kick();
        end
        chk("R5 flag stays clear", flag, 0);
        chk("R5 no reset", pulses - p0, 0);

        // R3/R6/R7: irq masked, restart inside window
        irq_en = 0;
        pulse_kick();
        step(70);
        chk("R3 irq masked", irq, 0);
        chk("R2 flag set", flag, 1);
        p0 = pulses;
        pulse_kick();
        step(30);
        chk("R6 restart cancels reset", pulses - p0, 0);
        chk("R7 flag survives restart", flag, 1);

        // R4: reset disabled
        rst_en = 0; irq_en = 1;
        pulse_clr(); pulse_kick();
        p0 = pulses;
        step(64 + WIN + 4);
        chk("R4 no pulse when disabled", pulses - p0, 0);
        rst_en = 1;

        // R2: clear on the expiry edge
        pulse_clr();
        pulse_kick();
        step(63);
        pulse_clr();
        chk("R2 set beats clear", flag, 1);

        // R6: restart on the final window edge
        pulse_clr();
        pulse_kick();
        p0 = pulses;
        step(63 + WIN);
        pulse_kick();
        step(5);
        chk("R6 last-edge restart", pulses - p0, 0);

        // R8: disabled, restarts ignored
        pulse_clr();
        en = 0;
        p0 = pulses;
        step(100); pulse_kick(); step(200);
        chk("R8 no flag while off", flag, 0);
        chk("R8 no reset while off", pulses - p0, 0);

        // R1: other selects
        tsel = 2'b01; en = 1;
        step(255);
        chk("R1 sel01 before", flag, 0);
        step(1);
        chk("R1 sel01 at 256", flag, 1);
        en = 0; pulse_clr(); step(2);
        tsel = 2'b11; en = 1;
        step(4095);
        chk("R1 sel11 before", flag, 0);
        step(1);
        chk("R1 sel11 at 4096", flag, 1);
        step(WIN + 4);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule